// File: doc/BRIEF.md
# Floating-point error interrupt handshake

This block sits between a processor's floating-point error output and the legacy interrupt path. The processor signals a pending numeric error by pulling an active-low error line low. The block brings that line into its own clock domain and, if the function is enabled, raises a level interrupt request. The interrupt handler acknowledges by writing to one fixed I/O port. That write drops the interrupt request and drives an active-low ignore-error output back to the processor. The ignore-error output stays low until the processor releases its error line.

A single configuration bit turns the whole function on or off. While it is clear, the error line raises nothing and port writes cause nothing. Clearing the bit while a handshake is in progress returns both outputs to their inactive levels on the next clock edge.

Top module: `fpu_err_bridge`

## Requirements
- R1: After a synchronous reset (rst_n low at a rising edge), irq_o is 0 and ignore_n is 1.
- R2: With cfg_enable high and no handshake in progress, holding err_n low makes irq_o go to 1 on the third rising edge after err_n falls. This is two synchroniser stages plus one output register. irq_o is still 0 after the second edge.
- R3: While irq_o is 1, an I/O write (io_wr high with io_addr equal to PORT_ADDR, default 16'h00F0) sampled at a rising edge makes irq_o 0 and ignore_n 0 after that same edge.
- R4: Once ignore_n is 0, it stays 0 while err_n stays low. It returns to 1 on the third rising edge after err_n rises. irq_o stays 0 throughout.
- R5: ignore_n only falls at an edge where irq_o was 1 and a port write was sampled.
- R6: If err_n rises while irq_o is 1 and no port write arrives, irq_o returns to 0 on the third rising edge after err_n rises.
- R7: io_wr low, or io_addr different from PORT_ADDR, has no effect on irq_o or ignore_n.
- R8: A port write sampled while irq_o is 0 and ignore_n is 1 has no effect. In particular, a write made while err_n is high does not assert ignore_n.
- R9: While cfg_enable is low, irq_o is 0 and ignore_n is 1 from the edge after it was sampled low. This holds regardless of err_n or port writes, and covers clearing it in the middle of a handshake.
- R10: If a port write is sampled at the same edge at which the synchronised error becomes inactive, the error release wins. Both outputs become inactive and ignore_n is not asserted.
- R11: irq_o high and ignore_n low never occur together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_enable | input | 1 | Function enable configuration bit |
| err_n | input | 1 | Active-low floating-point error from the processor, asynchronous |
| io_wr | input | 1 | I/O write strobe, one cycle per write |
| io_addr | input | ADDR_W | I/O write address |
| irq_o | output | 1 | Internal interrupt request, active high level |
| ignore_n | output | 1 | Active-low ignore-error output to the processor |

## Verification
Two events can coincide. One is the acknowledging port write. The other is the synchronised error line going inactive, and both can reach the handshake logic at the same clock edge. The bench provokes this directly: it raises err_n, waits until the synchroniser is one edge from showing the release, and places the port write on that edge. It then expects both outputs inactive with no ignore pulse. Random phases also place writes, enable drops and error edges close together, and every cycle is compared against a reference model in the bench.

// File: rtl/fpe_pkg.sv
// Package: shared types for the floating-point error handshake.
// Assumes: imported by every module of the block.
package fpe_pkg;

    // Handshake phases: quiet, interrupt pending, ignore asserted.
    typedef enum logic [1:0] {
        FPE_IDLE = 2'd0,
        FPE_PEND = 2'd1,
        FPE_IGN  = 2'd2
    } fpe_state_e;

endpackage

// File: rtl/fpe_sync.sv
// Module: fpe_sync
// What: multi-stage synchroniser for one asynchronous level.
// Assumes: STAGES >= 2; the input is a slow level, not a pulse.
module fpe_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] chain_q;

    // Shift the raw level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RESET_VAL}};
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d_i};
        end
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/fpe_port_decode.sv
// Module: fpe_port_decode
// What: flags a write strobe whose address matches the acknowledge port.
// Assumes: io_wr is high for exactly one cycle per write.
module fpe_port_decode #(
    parameter int              ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h00F0
) (
    input  logic              io_wr,
    input  logic [ADDR_W-1:0] io_addr,
    output logic              hit_o
);

    // Address compare qualified by the strobe.
    always_comb begin
        hit_o = io_wr && (io_addr == PORT_ADDR);
    end

endmodule

// File: rtl/fpe_handshake.sv
// Module: fpe_handshake
// What: interrupt / acknowledge / ignore sequencing with registered outputs.
// Assumes: err_act_i is already synchronous; ack_i is a one-cycle pulse.
module fpe_handshake
    import fpe_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    input  logic err_act_i,
    input  logic ack_i,
    output logic irq_o,
    output logic ignore_n_o
);

    fpe_state_e state_q;
    fpe_state_e state_d;

    // Next phase: a disabled function or a released error line return to
    // idle before an acknowledge is considered.
    always_comb begin
        state_d = state_q;
        if (!enable_i || !err_act_i) begin
            state_d = FPE_IDLE;
        end else begin
            unique case (state_q)
                FPE_IDLE: state_d = FPE_PEND;
                FPE_PEND: state_d = ack_i ? FPE_IGN : FPE_PEND;
                FPE_IGN:  state_d = FPE_IGN;
                default:  state_d = FPE_IDLE;
            endcase
        end
    end

    // Phase register plus output flops loaded from the next phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= FPE_IDLE;
            irq_o      <= 1'b0;
            ignore_n_o <= 1'b1;
        end else begin
            state_q    <= state_d;
            irq_o      <= (state_d == FPE_PEND);
            ignore_n_o <= (state_d != FPE_IGN);
        end
    end

endmodule

// File: rtl/fpu_err_bridge.sv
// Module: fpu_err_bridge (top)
// What: turns an active-low processor error into an interrupt request and
//       answers an acknowledge port write with an ignore-error level.
// Assumes: err_n is asynchronous; io_wr/io_addr and cfg_enable are
//          synchronous to clk.
module fpu_err_bridge #(
    parameter int                ADDR_W      = 16,
    parameter logic [ADDR_W-1:0] PORT_ADDR   = 16'h00F0,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_enable,
    input  logic              err_n,
    input  logic              io_wr,
    input  logic [ADDR_W-1:0] io_addr,
    output logic              irq_o,
    output logic              ignore_n
);

    logic err_n_sync;
    logic err_act;
    logic ack_hit;

    fpe_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (err_n),
        .q_o   (err_n_sync)
    );

    // Convert the synchronised level to active-high.
    assign err_act = ~err_n_sync;

    fpe_port_decode #(
        .ADDR_W    (ADDR_W),
        .PORT_ADDR (PORT_ADDR)
    ) u_decode (
        .io_wr   (io_wr),
        .io_addr (io_addr),
        .hit_o   (ack_hit)
    );

    fpe_handshake u_hs (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable_i   (cfg_enable),
        .err_act_i  (err_act),
        .ack_i      (ack_hit),
        .irq_o      (irq_o),
        .ignore_n_o (ignore_n)
    );

endmodule

// File: rtl/fpu_err_bridge_chk.sv
// Module: fpu_err_bridge_chk
// What: port-level properties of the handshake, bound to the top.
// Assumes: sees only the top module's ports.
module fpu_err_bridge_chk #(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h00F0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_enable,
    input logic              err_n,
    input logic              io_wr,
    input logic [ADDR_W-1:0] io_addr,
    input logic              irq_o,
    input logic              ignore_n
);

    logic ack_seen;
    assign ack_seen = io_wr && (io_addr == PORT_ADDR);

    // R3: an acknowledge during a pending interrupt drops it.
    p_ack_clears_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && ack_seen) |=> !irq_o);

    // R5: ignore only falls right after a pending interrupt was acknowledged.
    p_ignore_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ignore_n) |-> ($past(irq_o) && $past(io_wr) && ($past(io_addr) == PORT_ADDR)));

    // R7: anything but a matching write keeps ignore inactive from pending.
    p_stray_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !ack_seen) |=> ignore_n);

    // R8: with nothing pending, ignore cannot assert.
    p_idle_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_o && ignore_n) |=> ignore_n);

    // R9: disabled function leaves both outputs inactive.
    p_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |=> (!irq_o && ignore_n));

    // R11: interrupt and ignore are mutually exclusive.
    p_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_o && !ignore_n));

    // R4: ignore is only held while the error line was low three edges back.
    p_ignore_needs_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ignore_n && $past(!ignore_n)) |-> !$past(err_n, 3));

endmodule

bind fpu_err_bridge fpu_err_bridge_chk #(
    .ADDR_W    (ADDR_W),
    .PORT_ADDR (PORT_ADDR)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_enable (cfg_enable),
    .err_n      (err_n),
    .io_wr      (io_wr),
    .io_addr    (io_addr),
    .irq_o      (irq_o),
    .ignore_n   (ignore_n)
);

// File: tb/fpu_err_bridge_bench.sv
module fpu_err_bridge_bench;

    localparam int          CLK_P    = 10;
    localparam int          ADDR_W   = 16;
    localparam logic [15:0] PORT     = 16'h00F0;
    localparam int          RAND_CYC = 3000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_enable = 1'b0;
    logic              err_n = 1'b1;
    logic              io_wr = 1'b0;
    logic [ADDR_W-1:0] io_addr = '0;
    logic              irq_o;
    logic              ignore_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    fpu_err_bridge #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT), .SYNC_STAGES(2)) u_fpu_err_bridge (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .err_n(err_n),
        .io_wr(io_wr), .io_addr(io_addr), .irq_o(irq_o), .ignore_n(ignore_n)
    );

    // Reference model from the requirements: 0 idle, 1 pending, 2 ignore.
    function automatic int ref_next(int st, bit en, bit err_act, bit ack);
        if (!en || !err_act) return 0;
        if (st == 0) return 1;
        if (st == 1) return ack ? 2 : 1;
        return 2;
    endfunction

    int m_state = 0;
    bit m_s1 = 1'b1, m_s2 = 1'b1;
    bit compare_on = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state <= 0; m_s1 <= 1'b1; m_s2 <= 1'b1;
        end else begin
            m_s1 <= err_n;
            m_s2 <= m_s1;
            m_state <= ref_next(m_state, cfg_enable, !m_s2, io_wr && (io_addr == PORT));
        end
    end

    task automatic check(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic outs(string req, logic e_irq, logic e_ign_n);
        check(req, "irq_o", irq_o, e_irq);
        check(req, "ignore_n", ignore_n, e_ign_n);
    endtask

    task automatic edges(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic port_write(logic [ADDR_W-1:0] a, logic strobe);
        io_wr = strobe; io_addr = a;
        @(negedge clk);
        io_wr = 1'b0; io_addr = '0;
    endtask

    // Compare against the model on every cycle of the random phase.
    always @(negedge clk) begin
        if (compare_on) begin
            check("R2", "irq_o vs model", irq_o, m_state == 1);
            check("R4", "ignore_n vs model", ignore_n, m_state != 2);
        end
    end

    initial begin
        edges(3);
        rst_n = 1'b1;
        edges(1);
        outs("R1", 1'b0, 1'b1);

        // R9: disabled, error held, write offered.
        err_n = 1'b0;
        edges(5);
        outs("R9", 1'b0, 1'b1);
        port_write(PORT, 1'b1);
        outs("R9", 1'b0, 1'b1);
        err_n = 1'b1;
        edges(4);
        cfg_enable = 1'b1;
        edges(1);

        // R8: write with no error pending.
        port_write(PORT, 1'b1);
        outs("R8", 1'b0, 1'b1);

        // R2: latency of three edges.
        err_n = 1'b0;
        edges(2);
        outs("R2", 1'b0, 1'b1);
        edges(1);
        outs("R2", 1'b1, 1'b1);

        // R7: wrong address, then right address without strobe.
        port_write(16'h00F1, 1'b1);
        outs("R7", 1'b1, 1'b1);
        port_write(PORT, 1'b0);
        outs("R7", 1'b1, 1'b1);

        // R3: acknowledge.
        port_write(PORT, 1'b1);
        outs("R3", 1'b0, 1'b0);

        // R4: hold then release.
        edges(5);
        outs("R4", 1'b0, 1'b0);
        err_n = 1'b1;
        edges(2);
        outs("R4", 1'b0, 1'b0);
        edges(1);
        outs("R4", 1'b0, 1'b1);

        // R6: release without acknowledge.
        err_n = 1'b0;
        edges(4);
        outs("R6", 1'b1, 1'b1);
        err_n = 1'b1;
        edges(2);
        outs("R6", 1'b1, 1'b1);
        edges(1);
        outs("R6", 1'b0, 1'b1);

        // R10: acknowledge on the edge where the release arrives.
        err_n = 1'b0;
        edges(4);
        outs("R10", 1'b1, 1'b1);
        err_n = 1'b1;
        edges(2);
        port_write(PORT, 1'b1);
        outs("R10", 1'b0, 1'b1);
        edges(2);
        outs("R10", 1'b0, 1'b1);

        // R9: enable cleared mid-handshake (pending, then ignore).
        err_n = 1'b0;
        edges(4);
        outs("R2", 1'b1, 1'b1);
        cfg_enable = 1'b0;
        edges(1);
        outs("R9", 1'b0, 1'b1);
        cfg_enable = 1'b1;
        edges(1);
        outs("R9", 1'b1, 1'b1);
        port_write(PORT, 1'b1);
        outs("R3", 1'b0, 1'b0);
        cfg_enable = 1'b0;
        edges(1);
        outs("R9", 1'b0, 1'b1);
        err_n = 1'b1;
        cfg_enable = 1'b1;
        edges(4);
        outs("R11", 1'b0, 1'b1);

        // Random phase with model comparison; R5 and R11 are covered here.
        void'($urandom(32'd2718));
        compare_on = 1'b1;
        for (int c = 0; c < RAND_CYC; c++) begin
            if ($urandom_range(7) == 0) err_n = ~err_n;
            if ($urandom_range(47) == 0) cfg_enable = ~cfg_enable;
            io_wr = ($urandom_range(3) == 0);
            io_addr = ($urandom_range(1) == 0) ? PORT : ADDR_W'($urandom_range(255));
            @(negedge clk);
        end
        compare_on = 1'b0;
        io_wr = 1'b0;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule